// File: doc/BRIEF.md
# 8x8 Dequantize, Inverse Transform and Reconstruct

This block turns one 8x8 block of quantized transform coefficients back into 8-bit picture samples. On a start pulse it captures the coefficients, a per-position scale matrix, a per-position weight matrix, a shift amount and an 8x8 prediction. It dequantizes all 64 coefficients at once, then runs two passes of an 8-point integer inverse transform. Each pass transposes its input matrix and transforms one row per cycle through a single shared butterfly.

The second pass rounds every residual, adds it to the captured prediction and clips the sum to 0..255. It emits one finished row of eight pixels per cycle, in row order, and then pulses done. The block is used once per block. The caller waits for done before a new start takes effect, and may change its inputs freely once the start has been taken.

Top module: `recon8x8_idct`

## Requirements
- R1: While reset is held and after it is released with no start, row_valid_o and done_o are low.
- R2: Coefficient i (row i/8, column i%8, bits [16i+15:16i] of each flat matrix input) is dequantized as follows. The 16-bit product of scale and weight is truncated and read as signed. It is multiplied by the signed coefficient to a 32-bit product. That product is shifted left by qp_i with 32-bit wrap, rounded as (v+32)>>>6, and saturated to -32768..32767.
- R3: The 1-D transform of p0..p7 uses 16-bit wrapping arithmetic. Even terms: a0=p0+p4, a2=p0-p4, a4=(p2>>>1)-p6, a6=p2+(p6>>>1). Odd terms are summed at 32 bits and cut to 16: a1=p5-p3-p7-(p7>>>1), a3=p1+p7-p3-(p3>>>1), a5=p7-p1+p5+(p5>>>1), a7=p1+p3+p5+(p1>>>1). Second stage: b0=a0+a6, b1=a1+(a7>>>2), b2=a2+a4, b3=a3+(a5>>>2), b4=a2-a4, b5=(a3>>>2)-a5, b6=a0-a6, b7=a7-(a1>>>2).
- R4: The transform outputs 0..7 are, in order, b0+b7, b2+b5, b4+b3, b6+b1, b6-b1, b4-b3, b2-b5, b0-b7.
- R5: Each pass transposes its 8x8 input and then transforms every row. The first pass works on the dequantized matrix and the second on the first pass result. Pixel (r,c) is clip(((t+32)>>>6) + pred, 0, 255), where t is second-pass element (r,c) and pred is bits [64r+8c+7:64r+8c] of pred_i.
- R6: If start is sampled at clock edge k, row 0 appears after edge k+9 and rows arrive on consecutive cycles. done_o and row_valid_o are never high together.
- R7: A start seen while a block is in progress is ignored, and input changes after the start is taken have no effect on the block's result.
- R8: row_idx_o is 0 on the first row of a block and rises by one on each following row up to 7. Pixel column c of a row is carried on bits [8c+7:8c] of row_pix_o.
- R9: done_o is a one-cycle pulse in the cycle right after row 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture all inputs and begin a block when idle |
| coef_i | input | 1024 | 64 signed 16-bit coefficients, row-major |
| scale_i | input | 1024 | 64 unsigned 16-bit scale values |
| weight_i | input | 1024 | 64 unsigned 16-bit weight values |
| qp_i | input | QW | Dequantization left shift |
| pred_i | input | 512 | 64 unsigned 8-bit prediction samples, row-major |
| row_valid_o | output | 1 | A reconstructed row is present |
| row_idx_o | output | 3 | Index of the row on row_pix_o |
| row_pix_o | output | 64 | Eight reconstructed pixels, column 0 in the low byte |
| done_o | output | 1 | Block finished, one-cycle pulse |

## Verification
The properties depend on a few conditions outside the block. Reset must be held across at least one rising edge. Nothing but a start taken while idle may begin a row stream. Given those, the output framing becomes a matter of the block's own sequencing, whatever the data values are.

The stimulus meets these conditions. Reset is held for several cycles. Starts are single-cycle pulses placed either while idle or, on purpose, in the middle of a block. Coefficients range from small realistic values up to full-scale extremes with large shifts, so dequantization saturation and the wrapping shift are reached without relying on any assumption about data.

// File: rtl/recon8x8_idct.sv
module recon8x8_idct #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1023:0] coef_i,
  input  logic [1023:0] scale_i,
  input  logic [1023:0] weight_i,
  input  logic [QW-1:0] qp_i,
  input  logic [511:0]  pred_i,
  output logic          row_valid_o,
  output logic [2:0]    row_idx_o,
  output logic [63:0]   row_pix_o,
  output logic          done_o
);
  typedef enum logic [1:0] {IDLE, P1, P2, FIN} st_t;
  st_t st;
  logic [2:0] cnt;
  logic [63:0][15:0] a_q;
  logic [7:0][7:0][15:0] b_q;
  logic [511:0] pred_q;
  logic [63:0][15:0] deq;
  logic [7:0][15:0] xin, xout;
  logic [63:0] pix;

  for (genvar i = 0; i < 64; i++) begin : g_deq
    logic [15:0] mw;
    logic signed [31:0] prod, shl;
    logic signed [32:0] ext, rnd;
    assign mw   = scale_i[16*i +: 16] * weight_i[16*i +: 16];
    assign prod = $signed(coef_i[16*i +: 16]) * $signed(mw);
    assign shl  = prod <<< qp_i;
    assign ext  = shl;
    assign rnd  = (ext + 33'sd32) >>> 6;
    assign deq[i] = (rnd > 33'sd32767)  ? 16'h7fff :
                    (rnd < -33'sd32768) ? 16'h8000 : rnd[15:0];
  end

  function automatic logic [7:0][15:0] xf(input logic [7:0][15:0] p);
    logic signed [15:0] s0, s1, s2, s3, s4, s5, s6, s7;
    logic signed [31:0] w1, w3, w5, w7, t1, t3, t5, t7;
    logic signed [15:0] y0, y1, y2, y3, y4, y5, y6, y7;
    logic signed [15:0] z0, z1, z2, z3, z4, z5, z6, z7;
    logic [7:0][15:0] o;
    s0 = p[0]; s1 = p[1]; s2 = p[2]; s3 = p[3];
    s4 = p[4]; s5 = p[5]; s6 = p[6]; s7 = p[7];
    w1 = s1; w3 = s3; w5 = s5; w7 = s7;
    y0 = s0 + s4;
    y2 = s0 - s4;
    y4 = (s2 >>> 1) - s6;
    y6 = s2 + (s6 >>> 1);
    t1 = w5 - w3 - w7 - (w7 >>> 1);
    t3 = w1 + w7 - w3 - (w3 >>> 1);
    t5 = w7 - w1 + w5 + (w5 >>> 1);
    t7 = w3 + w5 + w1 + (w1 >>> 1);
    y1 = t1[15:0]; y3 = t3[15:0]; y5 = t5[15:0]; y7 = t7[15:0];
    z0 = y0 + y6;
    z1 = y1 + (y7 >>> 2);
    z2 = y2 + y4;
    z3 = y3 + (y5 >>> 2);
    z4 = y2 - y4;
    z5 = (y3 >>> 2) - y5;
    z6 = y0 - y6;
    z7 = y7 - (y1 >>> 2);
    o[0] = z0 + z7; o[1] = z2 + z5; o[2] = z4 + z3; o[3] = z6 + z1;
    o[4] = z6 - z1; o[5] = z4 - z3; o[6] = z2 - z5; o[7] = z0 - z7;
    return o;
  endfunction

  for (genvar k = 0; k < 8; k++) begin : g_col
    logic signed [16:0] rr;
    logic signed [17:0] sm;
    assign xin[k] = (st == P2) ? b_q[k][cnt] : a_q[k*8 + 32'(cnt)];
    assign rr = ($signed({xout[k][15], xout[k]}) + 17'sd32) >>> 6;
    assign sm = 18'(rr) + $signed({10'd0, pred_q[32'(cnt)*64 + k*8 +: 8]});
    assign pix[8*k +: 8] = (sm < 0) ? 8'd0 : (sm > 18'sd255) ? 8'd255 : sm[7:0];
  end

  assign xout = xf(xin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      row_valid_o <= 1'b0;
      row_idx_o <= '0;
      row_pix_o <= '0;
      done_o <= 1'b0;
    end else begin
      row_valid_o <= 1'b0;
      done_o <= 1'b0;
      case (st)
        IDLE: if (start) begin
          a_q <= deq;
          pred_q <= pred_i;
          cnt <= '0;
          st <= P1;
        end
        P1: begin
          b_q[cnt] <= xout;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= P2;
        end
        P2: begin
          row_valid_o <= 1'b1;
          row_idx_o <= cnt;
          row_pix_o <= pix;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= FIN;
        end
        default: begin
          done_o <= 1'b1;
          st <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/recon8x8_idct_chk.sv
module recon8x8_idct_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       row_valid_o,
  input logic [2:0] row_idx_o,
  input logic       done_o
);
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_valid_o && done_o));
  assert_first_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_valid_o) |-> row_idx_o == 3'd0);
  assert_rows_ascend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid_o && $past(row_valid_o)) |-> row_idx_o == $past(row_idx_o) + 3'd1);
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(row_valid_o) && $past(row_idx_o) == 3'd7));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind recon8x8_idct recon8x8_idct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .row_valid_o(row_valid_o),
  .row_idx_o(row_idx_o), .done_o(done_o)
);

// File: tb/tb_recon8x8_idct.sv
module tb_recon8x8_idct;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1023:0] coef_i = '0, scale_i = '0, weight_i = '0;
  logic [3:0] qp_i = '0;
  logic [511:0] pred_i = '0;
  logic row_valid_o, done_o;
  logic [2:0] row_idx_o;
  logic [63:0] row_pix_o;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [66:0] expq[$];

  typedef shortint v8_t[8];

  recon8x8_idct dut (.*);

  always #5 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  function automatic shortint deq1(int c, int s, int w, int q);
    shortint x; int p, sh; longint r;
    x = shortint'(s * w);
    p = c * int'(x);
    sh = p << q;
    r = (longint'(sh) + 32) >>> 6;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return shortint'(r);
  endfunction

  function automatic v8_t xf1(v8_t p);
    shortint y0, y1, y2, y3, y4, y5, y6, y7, z0, z1, z2, z3, z4, z5, z6, z7;
    int q1, q3, q5, q7; v8_t o;
    y0 = p[0] + p[4]; y2 = p[0] - p[4];
    y4 = (p[2] >>> 1) - p[6]; y6 = p[2] + (p[6] >>> 1);
    q1 = int'(p[5]) - p[3] - p[7] - (p[7] >>> 1);
    q3 = int'(p[1]) + p[7] - p[3] - (p[3] >>> 1);
    q5 = int'(p[7]) - p[1] + p[5] + (p[5] >>> 1);
    q7 = int'(p[3]) + p[5] + p[1] + (p[1] >>> 1);
    y1 = shortint'(q1); y3 = shortint'(q3); y5 = shortint'(q5); y7 = shortint'(q7);
    z0 = y0 + y6; z1 = y1 + (y7 >>> 2); z2 = y2 + y4; z3 = y3 + (y5 >>> 2);
    z4 = y2 - y4; z5 = (y3 >>> 2) - y5; z6 = y0 - y6; z7 = y7 - (y1 >>> 2);
    o[0] = z0 + z7; o[1] = z2 + z5; o[2] = z4 + z3; o[3] = z6 + z1;
    o[4] = z6 - z1; o[5] = z4 - z3; o[6] = z2 - z5; o[7] = z0 - z7;
    return o;
  endfunction

  // driver: computes expected rows (R2 R3 R4 R5), pushes them, runs the block
  task automatic run_block(bit restart_mid);
    shortint m[8][8], t[8][8];
    v8_t v, o;
    int n, rows;
    for (int i = 0; i < 64; i++)
      m[i/8][i%8] = deq1(int'($signed(coef_i[16*i +: 16])), int'(scale_i[16*i +: 16]),
                         int'(weight_i[16*i +: 16]), int'(qp_i));
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < 8; r++) begin
        for (int k = 0; k < 8; k++) v[k] = m[k][r];
        o = xf1(v);
        for (int k = 0; k < 8; k++) t[r][k] = o[k];
      end
      m = t;
    end
    for (int r = 0; r < 8; r++) begin
      logic [63:0] px;
      for (int c = 0; c < 8; c++) begin
        int s;
        s = ((int'(m[r][c]) + 32) >>> 6) + int'(pred_i[64*r + 8*c +: 8]);
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        px[8*c +: 8] = 8'(s);
      end
      expq.push_back({3'(r), px});
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 1; rows = 0;
    while (!done_o && n < 40) begin
      if (row_valid_o && rows == 0) begin
        checks++;
        if (n != 10) begin
          fails++;
          $display("FAIL R6 first row latency actual=%0d expected=10", n);
        end
      end
      if (row_valid_o) rows++;
      if (restart_mid && n == 3) begin
        // R7: new start and changed inputs while busy
        start = 1; coef_i = ~coef_i; pred_i = ~pred_i; qp_i = qp_i + 4'd3;
      end else start = 0;
      @(negedge clk); n++;
    end
    checks++;
    if (n != 18 || rows != 8) begin
      fails++;
      $display("FAIL R6 R9 done timing actual=%0d/%0d rows expected=18/8", n, rows);
    end
    @(negedge clk);
    checks++;
    if (done_o !== 1'b0) begin
      fails++;
      $display("FAIL R9 done width actual=%b expected=0", done_o);
    end
    repeat (25) @(negedge clk);  // R7: no extra rows (monitor flags them)
  endtask

  // monitor: pops and compares (R2 R3 R4 R5 R8)
  always @(negedge clk) begin
    if (rst_n && row_valid_o) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected row actual=%0d/%h expected=none", row_idx_o, row_pix_o);
      end else begin
        logic [66:0] e;
        e = expq.pop_front();
        if ({row_idx_o, row_pix_o} !== e) begin
          fails++;
          $display("FAIL R2 R3 R4 R5 R8 row actual=%0d/%h expected=%0d/%h",
                   row_idx_o, row_pix_o, e[66:64], e[63:0]);
        end
      end
    end
  end

  task automatic fill(int mode);
    for (int i = 0; i < 64; i++) begin
      case (mode)
        0: begin coef_i[16*i +: 16] = 16'($urandom_range(0, 128)) - 16'd64;
                 scale_i[16*i +: 16] = 16'($urandom_range(10, 25));
                 weight_i[16*i +: 16] = 16'd16; end
        1: begin coef_i[16*i +: 16] = (i % 2) ? 16'h8000 : 16'h7fff;
                 scale_i[16*i +: 16] = 16'd16; weight_i[16*i +: 16] = 16'd16; end
        default: begin coef_i[16*i +: 16] = 16'($urandom);
                 scale_i[16*i +: 16] = 16'($urandom); weight_i[16*i +: 16] = 16'($urandom); end
      endcase
    end
    for (int i = 0; i < 64; i++) pred_i[8*i +: 8] = 8'($urandom);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (row_valid_o !== 1'b0 || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b expected=00", row_valid_o, done_o);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (row_valid_o !== 1'b0 || done_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle outputs actual=%b%b expected=00", row_valid_o, done_o);
    end
    // single DC coefficient
    coef_i = '0; scale_i = '0; weight_i = '0;
    coef_i[15:0] = 16'd40; scale_i[15:0] = 16'd16; weight_i[15:0] = 16'd16; qp_i = 4'd2;
    for (int i = 0; i < 64; i++) pred_i[8*i +: 8] = 8'(i * 3);
    run_block(0);
    for (int b = 0; b < 6; b++) begin fill(0); qp_i = 4'($urandom_range(0, 5)); run_block(0); end
    fill(1); qp_i = 4'd8;  run_block(0);
    fill(1); qp_i = 4'd15; run_block(0);
    for (int b = 0; b < 3; b++) begin fill(2); qp_i = 4'($urandom); run_block(0); end
    fill(0); qp_i = 4'd3; run_block(1);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R6 missing rows actual=%0d expected=0", expq.size());
    end
    summary();
  end
endmodule